// File: doc/BRIEF.md
# Set-Associative Tag Directory with Exact LRU

This block is the lookup and replacement engine of a cache. It holds the tags, the valid bits, the dirty bits and a complete recency order for every set. Each cycle it can take one byte address with a read/write flag. It answers whether the block is present, and which way matched or was chosen for the fill. When the chosen victim holds modified data, it also asks for that block to be written back. The block itself holds no data. The data array, the refill path and the memory bus are handled elsewhere.

An address is cut into three fields. From the top down they are the tag, the set index and the byte offset. The set count is a power of two, and the index may be zero bits wide, which gives a fully associative directory. The way count may be any positive integer: one way gives a direct-mapped directory, and odd counts such as 3, 7 or 9 work without padding. Every miss allocates: the selected way takes the new tag and becomes most recent, on reads and on writes.

Top module: `lru_tag_directory`

## Requirements
- R1: The tag is the top ADDR_W-OFFS_W-SET_W address bits. The set index is the SET_W bits just above the low OFFS_W offset bits. Two addresses that differ only in offset bits refer to the same block, and addresses with different index bits live in different sets.
- R2: A response appears exactly one cycle after a request (rsp_valid high in the cycle after req_valid). rsp_valid is low in any cycle that follows a cycle without a request.
- R3: rsp_hit is 1 when a valid way of the indexed set holds the request's tag, and rsp_way then gives that way's number.
- R4: On a miss, if the set has an invalid way, the lowest-numbered invalid way is filled, and rsp_way reports it.
- R5: When every way of the set is valid, a miss replaces the least recently used way. Both hits and fills make the touched way the most recent.
- R6: A way count that is not a power of two works: in the default 3-way set, a fourth distinct tag evicts the least recent of the three.
- R7: With WRITE_BACK=1, a write hit marks the block dirty and a write miss fills the block dirty, while a read miss fills it clean. A miss whose victim is valid and dirty raises wb_req with the victim's tag on wb_tag. A clean or invalid victim leaves wb_req low.
- R8: With WRITE_BACK=0, no dirty state is kept and wb_req never rises, even after write misses that evict.
- R9: Reset clears every valid and dirty bit and sets each set's order to way 0 as most recent through way N-1 as least recent. After reset, rsp_valid and wb_req are low, and an address seen before the reset misses.
- R10: With four one-byte blocks in two ways, the repeating sequence 0,4 misses twice and then always hits.
- R11: With four one-byte blocks, the repeating sequence 0,4 never hits when direct mapped. The repeating sequence 0,2,4 never hits with two ways, and hits once every three accesses (on address 2) when direct mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_addr | input | ADDR_W | Byte address of the lookup |
| req_write | input | 1 | 1 for a store, 0 for a load |
| rsp_valid | output | 1 | Result of the previous cycle's request is present |
| rsp_hit | output | 1 | The block was present |
| rsp_way | output | WAY_W | Matching way on a hit, filled way on a miss |
| wb_req | output | 1 | The evicted victim was dirty and must be written back |
| wb_tag | output | TAG_W | Tag of the evicted victim when wb_req is high |

## Verification
A dirty eviction and the fill that replaces it happen in the same cycle and in the same way. The state of that set changes at the same edge that registers the response. The bench therefore sends two requests to one full set back to back. The first request must report wb_req with the old tag. The second request, which asks for the tag just evicted, must miss and pick the next least recent way. This shows that the second lookup saw the fill, the new dirty bit and the reordered recency from the first request, with no idle cycle between them.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  // Index width for a count of items; never less than one bit.
  function automatic int idx_width(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tagdir_rst_sync.sv
module tagdir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/tagdir_match.sv
module tagdir_match #(
  parameter int WAYS  = 3,
  parameter int TAG_W = 8,
  parameter int WAY_W = 2
) (
  input  logic [TAG_W-1:0]            lookup_tag,
  input  logic [WAYS-1:0][TAG_W-1:0]  row_tags,
  input  logic [WAYS-1:0]             row_vld,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = row_vld[w] && (row_tags[w] == lookup_tag);
  end

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (eq[w]) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/tagdir_victim.sv
module tagdir_victim #(
  parameter int WAYS  = 3,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]             row_vld,
  input  logic [WAYS-1:0][WAY_W-1:0]  row_ord,
  output logic [WAY_W-1:0]            victim
);
  logic             any_free;
  logic [WAY_W-1:0] free_way;

  // Scan downward so the lowest invalid way wins.
  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!row_vld[w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    victim = any_free ? free_way : row_ord[WAYS-1];
  end
endmodule

// File: rtl/tagdir_recency.sv
module tagdir_recency #(
  parameter int WAYS  = 3,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0][WAY_W-1:0]  ord_in,
  input  logic [WAY_W-1:0]            touched,
  output logic [WAYS-1:0][WAY_W-1:0]  ord_out
);
  // Position 0 holds the most recent way, position WAYS-1 the least recent.
  int unsigned pos;

  always_comb begin
    pos = WAYS - 1;
    for (int p = 0; p < WAYS; p++) begin
      if (ord_in[p] == touched) pos = p;
    end
  end

  for (genvar p = 0; p < WAYS; p++) begin : g_slot
    if (p == 0) begin : g_head
      assign ord_out[p] = touched;
    end else begin : g_tail
      assign ord_out[p] = (p <= pos) ? ord_in[p-1] : ord_in[p];
    end
  end
endmodule

// File: rtl/lru_tag_directory.sv
module lru_tag_directory #(
  parameter int ADDR_W     = 12,
  parameter int OFFS_W     = 2,
  parameter int SET_W      = 2,
  parameter int WAYS       = 3,
  parameter int WRITE_BACK = 1,
  localparam int TAG_W     = ADDR_W - OFFS_W - SET_W,
  localparam int WAY_W     = tagdir_pkg::idx_width(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              wb_req,
  output logic [TAG_W-1:0]  wb_tag
);
  localparam int SETS   = 1 << SET_W;
  localparam int SIDX_W = (SET_W > 0) ? SET_W : 1;

  logic rst_int_n;

  tagdir_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  // State arrays, one row per set
  logic [WAYS-1:0][TAG_W-1:0]  tag_q [SETS];
  logic [WAYS-1:0]             vld_q [SETS];
  logic [WAYS-1:0]             dty_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0]  ord_q [SETS];

  // Field extraction
  logic [SIDX_W-1:0] set_idx;
  logic [TAG_W-1:0]  req_tag;

  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

  if (SET_W > 0) begin : g_indexed
    assign set_idx = req_addr[OFFS_W +: SET_W];
  end else begin : g_single_set
    assign set_idx = '0;
  end

  // Current row
  logic [WAYS-1:0][TAG_W-1:0]  cur_tag;
  logic [WAYS-1:0]             cur_vld;
  logic [WAYS-1:0]             cur_dty;
  logic [WAYS-1:0][WAY_W-1:0]  cur_ord;

  assign cur_tag = tag_q[set_idx];
  assign cur_vld = vld_q[set_idx];
  assign cur_dty = dty_q[set_idx];
  assign cur_ord = ord_q[set_idx];

  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] victim_way;
  logic [WAY_W-1:0] sel_way;
  logic             do_wb;

  tagdir_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .lookup_tag(req_tag), .row_tags(cur_tag), .row_vld(cur_vld),
    .hit(hit), .hit_way(hit_way)
  );

  tagdir_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .row_vld(cur_vld), .row_ord(cur_ord), .victim(victim_way)
  );

  assign sel_way = hit ? hit_way : victim_way;

  logic [WAYS-1:0][WAY_W-1:0] nxt_ord;

  tagdir_recency #(.WAYS(WAYS), .WAY_W(WAY_W)) u_recency (
    .ord_in(cur_ord), .touched(sel_way), .ord_out(nxt_ord)
  );

  // Next-state for the indexed row
  logic [WAYS-1:0][TAG_W-1:0] nxt_tag;
  logic [WAYS-1:0]            nxt_vld;
  logic [WAYS-1:0]            nxt_dty;

  always_comb begin
    nxt_tag          = cur_tag;
    nxt_vld          = cur_vld;
    nxt_tag[sel_way] = req_tag;
    nxt_vld[sel_way] = 1'b1;
  end

  if (WRITE_BACK != 0) begin : g_wb
    always_comb begin
      nxt_dty          = cur_dty;
      nxt_dty[sel_way] = hit ? (cur_dty[sel_way] | req_write) : req_write;
    end
    assign do_wb = !hit && cur_vld[victim_way] && cur_dty[victim_way];
  end else begin : g_wt
    assign nxt_dty = '0;
    assign do_wb   = 1'b0;
  end

  // Registers
  logic             rsp_valid_q;
  logic             rsp_wb_q;
  logic             rsp_hit_q;
  logic [WAY_W-1:0] rsp_way_q;
  logic [TAG_W-1:0] rsp_wbtag_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid_q <= 1'b0;
      rsp_wb_q    <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) ord_q[s][w] <= WAY_W'(w);
      end
    end else begin
      rsp_valid_q <= req_valid;
      rsp_wb_q    <= req_valid && do_wb;
      if (req_valid) begin
        vld_q[set_idx] <= nxt_vld;
        dty_q[set_idx] <= nxt_dty;
        ord_q[set_idx] <= nxt_ord;
      end
    end
  end

  // Tags and payload need no reset: valid bits and rsp_valid qualify them.
  always_ff @(posedge clk) begin
    if (req_valid) begin
      tag_q[set_idx] <= nxt_tag;
      rsp_hit_q      <= hit;
      rsp_way_q      <= sel_way;
      rsp_wbtag_q    <= cur_tag[victim_way];
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_way   = rsp_way_q;
  assign wb_req    = rsp_wb_q;
  assign wb_tag    = rsp_wbtag_q;
endmodule

// File: rtl/tagdir_checker.sv
module tagdir_checker #(
  parameter int ADDR_W = 12,
  parameter int WAYS   = 3,
  parameter int WAY_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [WAY_W-1:0]  rsp_way,
  input logic              wb_req
);
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_rsp_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R7: a writeback only accompanies a miss
  p_wb_only_on_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (rsp_valid && !rsp_hit));

  p_way_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (int'(rsp_way) < WAYS));

  // R3/R5: a repeat of the previous request hits the way just touched
  p_repeat_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid) && req_addr == $past(req_addr))
    |=> (rsp_hit && rsp_way == $past(rsp_way)));
endmodule

bind lru_tag_directory tagdir_checker #(.ADDR_W(ADDR_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .wb_req(wb_req)
);

// File: tb/tb_lru_tag_directory.sv
module tb_lru_tag_directory;
  localparam int CLK_PERIOD = 10;

  logic clk;
  logic rst_n;
  int   n_chk;
  int   n_err;
  bit   done;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Main: 3-way, 4 sets, 4-byte blocks, write-back, tag = addr[11:4], set = addr[3:2]
  logic m_v, m_w, m_rv, m_h, m_wb;
  logic [11:0] m_a;
  logic [1:0]  m_way;
  logic [7:0]  m_wt;
  // Two-way: 4 one-byte blocks, set = addr[0]
  logic t_v, t_w, t_rv, t_h, t_wb;
  logic [3:0] t_a;
  logic [0:0] t_way;
  logic [2:0] t_wt;
  // Direct mapped, write-through: set = addr[1:0]
  logic d_v, d_w, d_rv, d_h, d_wb;
  logic [3:0] d_a;
  logic [0:0] d_way;
  logic [1:0] d_wt;

  lru_tag_directory dut (
    .clk(clk), .rst_n(rst_n), .req_valid(m_v), .req_addr(m_a), .req_write(m_w),
    .rsp_valid(m_rv), .rsp_hit(m_h), .rsp_way(m_way), .wb_req(m_wb), .wb_tag(m_wt));

  lru_tag_directory #(.ADDR_W(4), .OFFS_W(0), .SET_W(1), .WAYS(2), .WRITE_BACK(1)) dut_2w (
    .clk(clk), .rst_n(rst_n), .req_valid(t_v), .req_addr(t_a), .req_write(t_w),
    .rsp_valid(t_rv), .rsp_hit(t_h), .rsp_way(t_way), .wb_req(t_wb), .wb_tag(t_wt));

  lru_tag_directory #(.ADDR_W(4), .OFFS_W(0), .SET_W(2), .WAYS(1), .WRITE_BACK(0)) dut_dm (
    .clk(clk), .rst_n(rst_n), .req_valid(d_v), .req_addr(d_a), .req_write(d_w),
    .rsp_valid(d_rv), .rsp_hit(d_h), .rsp_way(d_way), .wb_req(d_wb), .wb_tag(d_wt));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int which, input logic v, input logic [11:0] a, input logic wr);
    case (which)
      0: begin m_v = v; m_a = a;       m_w = wr; end
      1: begin t_v = v; t_a = a[3:0];  t_w = wr; end
      default: begin d_v = v; d_a = a[3:0]; d_w = wr; end
    endcase
  endtask

  task automatic sample(input int which, output logic v, output logic h, output int wy,
                        output logic wb, output int wt);
    case (which)
      0: begin v = m_rv; h = m_h; wy = int'(m_way); wb = m_wb; wt = int'(m_wt); end
      1: begin v = t_rv; h = t_h; wy = int'(t_way); wb = t_wb; wt = int'(t_wt); end
      default: begin v = d_rv; h = d_h; wy = int'(d_way); wb = d_wb; wt = int'(d_wt); end
    endcase
  endtask

  // One isolated access, followed by an idle cycle.
  task automatic acc(input int which, input logic [11:0] a, input logic wr,
                     output logic h, output int wy, output logic wb, output int wt);
    logic v;
    @(negedge clk);
    drive(which, 1'b1, a, wr);
    @(negedge clk);
    drive(which, 1'b0, a, 1'b0);
    sample(which, v, h, wy, wb, wt);
    chk(v == 1'b1, "R2 rsp_valid after request", int'(v), 1);
  endtask

  // One access with all results checked.
  task automatic expect_acc(input int which, input logic [11:0] a, input logic wr,
                            input logic eh, input int ew, input logic ewb, input int ewt,
                            input string req);
    logic h, wb;
    int   wy, wt;
    acc(which, a, wr, h, wy, wb, wt);
    chk(h == eh, {req, " hit"}, int'(h), int'(eh));
    if (ew >= 0) chk(wy == ew, {req, " way"}, wy, ew);
    chk(wb == ewb, {req, " wb_req"}, int'(wb), int'(ewb));
    if (ewb) chk(wt == ewt, {req, " wb_tag"}, wt, ewt);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(0, 1'b0, 12'h0, 1'b0);
    drive(1, 1'b0, 12'h0, 1'b0);
    drive(2, 1'b0, 12'h0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(m_rv == 1'b0, "R9 rsp_valid after reset", int'(m_rv), 0);
    chk(m_wb == 1'b0, "R9 wb_req after reset", int'(m_wb), 0);
  endtask

  task automatic t_fields_and_fill();
    // R4: empty set fills way 0; R1: offset change still hits
    expect_acc(0, 12'h104, 1'b0, 1'b0, 0, 1'b0, 0, "R4 first fill");
    expect_acc(0, 12'h107, 1'b0, 1'b1, 0, 1'b0, 0, "R1 offset ignored");
    // R1: other index bits select another (empty) set
    expect_acc(0, 12'h108, 1'b0, 1'b0, 0, 1'b0, 0, "R1 other set");
    expect_acc(0, 12'h204, 1'b1, 1'b0, 1, 1'b0, 0, "R4 next free way");
    expect_acc(0, 12'h304, 1'b0, 1'b0, 2, 1'b0, 0, "R4 last free way");
    expect_acc(0, 12'h204, 1'b0, 1'b1, 1, 1'b0, 0, "R3 hit reports way");
  endtask

  task automatic t_lru_and_writeback();
    // Set 1 order now: w1, w2, w0. Touch A to make w2 least recent... then B
    expect_acc(0, 12'h304, 1'b0, 1'b1, 2, 1'b0, 0, "R5 hit touch C");
    expect_acc(0, 12'h104, 1'b0, 1'b1, 0, 1'b0, 0, "R5 hit touch A");
    // Order A,C,B: B (way 1, dirty from write fill) is evicted
    expect_acc(0, 12'h404, 1'b0, 1'b0, 1, 1'b1, 8'h20, "R6 R7 dirty LRU evicted");
    // Order D,A,C: C in way 2 is clean
    expect_acc(0, 12'h204, 1'b0, 1'b0, 2, 1'b0, 0, "R7 clean victim no wb");
    // Write hit on A marks it dirty; order A,B,D
    expect_acc(0, 12'h104, 1'b1, 1'b1, 0, 1'b0, 0, "R7 write hit");
    expect_acc(0, 12'h304, 1'b0, 1'b0, 1, 1'b0, 0, "R5 evict LRU D");
    // Order C,A,B: B clean in way 2
    expect_acc(0, 12'h504, 1'b0, 1'b0, 2, 1'b0, 0, "R5 evict LRU B");
    // Order E,C,A: A dirty via write hit
    expect_acc(0, 12'h604, 1'b0, 1'b0, 0, 1'b1, 8'h10, "R7 write hit made dirty");
  endtask

  // Dirty eviction and a dependent lookup in consecutive cycles
  task automatic t_back_to_back();
    logic v1, h1, wb1, v2, h2, wb2;
    int   wy1, wt1, wy2, wt2;
    expect_acc(0, 12'h00C, 1'b1, 1'b0, 0, 1'b0, 0, "R7 write fill set 3");
    expect_acc(0, 12'h10C, 1'b0, 1'b0, 1, 1'b0, 0, "R4 fill set 3");
    expect_acc(0, 12'h20C, 1'b0, 1'b0, 2, 1'b0, 0, "R4 fill set 3");
    @(negedge clk);
    drive(0, 1'b1, 12'h30C, 1'b0);
    @(negedge clk);
    sample(0, v1, h1, wy1, wb1, wt1);
    drive(0, 1'b1, 12'h00C, 1'b0);
    @(negedge clk);
    sample(0, v2, h2, wy2, wb2, wt2);
    drive(0, 1'b0, 12'h0, 1'b0);
    chk(v1 && v2, "R2 back-to-back valid", int'(v1 & v2), 1);
    chk(!h1 && wy1 == 0, "R5 b2b evicts way 0", wy1, 0);
    chk(wb1 && wt1 == 8'h00, "R7 b2b wb tag", wt1, 0);
    chk(!h2, "R3 b2b evicted tag misses", int'(h2), 0);
    chk(wy2 == 1 && !wb2, "R5 b2b next LRU way 1 clean", wy2, 1);
    @(negedge clk);
    chk(m_rv == 1'b0, "R2 idle after b2b", int'(m_rv), 0);
    expect_acc(0, 12'h30C, 1'b0, 1'b1, 0, 1'b0, 0, "R5 b2b fill visible");
  endtask

  task automatic t_reset_clears();
    do_reset();
    expect_acc(0, 12'h30C, 1'b0, 1'b0, 0, 1'b0, 0, "R9 miss after reset");
    expect_acc(0, 12'h504, 1'b0, 1'b0, 0, 1'b0, 0, "R9 miss after reset");
  endtask

  task automatic t_pattern_04();
    do_reset();
    for (int i = 0; i < 6; i++) begin
      logic [11:0] a;
      a = (i % 2 == 0) ? 12'd0 : 12'd4;
      expect_acc(1, a, 1'b0, (i >= 2), -1, 1'b0, 0, "R10 two-way 0,4");
      expect_acc(2, a, 1'b1, 1'b0, 0, 1'b0, 0, "R11 R8 direct 0,4");
    end
  endtask

  task automatic t_pattern_024();
    do_reset();
    for (int i = 0; i < 9; i++) begin
      logic [11:0] a;
      a = (i % 3 == 0) ? 12'd0 : ((i % 3 == 1) ? 12'd2 : 12'd4);
      expect_acc(1, a, 1'b0, 1'b0, -1, 1'b0, 0, "R11 two-way 0,2,4");
      expect_acc(2, a, 1'b1, (i >= 3 && i % 3 == 1), 0, 1'b0, 0, "R11 R8 direct 0,2,4");
    end
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    done  = 1'b0;
    t_reset_state();
    t_fields_and_fill();
    t_lru_and_writeback();
    t_back_to_back();
    t_reset_clears();
    t_pattern_04();
    t_pattern_024();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule